// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block steps one switchable power domain between its off and on states in a fixed order, one control output per clock. It drives the domain's reset-release, isolation, two power-switch enables, clock disable, a group of SRAM power-down lines and a bus-protection request. It waits on acknowledge inputs from the switches, the SRAM macros and the bus fabric between steps. Every wait is bounded by a cycle counter. If that counter runs out, the sequence aborts into a fault state and the outputs stay where they were.

A parent controller pulses `on_req_i` or `off_req_i` while the sequencer is idle. It then watches `busy_o`, `done_o`, `err_o` and `state_o`. Each instance is configured by parameters:

- the number of SRAM power-down lines,
- the number of SRAM acknowledge lines, and a mask choosing which of them count (the mask may be empty),
- whether the domain uses bus protection,
- a single timeout limit shared by all waits.

All acknowledge inputs are assumed to be synchronous to `clk_i`.

Top module: `pwr_domain_seq`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first request, the outputs hold the off state:
  - `rst_rel_o`=0, `iso_o`=1, `pwr_on_o`=0, `pwr_on2_o`=0, `clk_dis_o`=1;
  - every `sram_pdn_o` bit is 1;
  - `bus_prot_req_o`=1 when bus protection is used, otherwise 0;
  - `busy_o`=0, `done_o`=0, `err_o`=0, and `state_o`=0 (state codes: 0 off, 1 on, 2 fault).
- R2: Power-up proceeds in this order, and protection is released only after the SRAM handshake:
  1. raise `pwr_on_o`, then raise `pwr_on2_o`;
  2. wait until both `pwr_ack_i` and `pwr_ack2_i` are 1;
  3. lower `clk_dis_o`, then lower `iso_o`, then raise `rst_rel_o`;
  4. clear all `sram_pdn_o` bits and wait until every masked `sram_ack_i` bit is 0;
  5. lower `bus_prot_req_o` and wait for `bus_prot_ack_i`=0;
  6. finish in state 1.
- R3: Power-down proceeds in this order, and protection is applied before any SRAM line moves:
  1. raise `bus_prot_req_o` and wait for `bus_prot_ack_i`=1;
  2. set all `sram_pdn_o` bits and wait until every masked `sram_ack_i` bit is 1;
  3. raise `iso_o`, lower `rst_rel_o`, raise `clk_dis_o`, lower `pwr_on_o`, then lower `pwr_on2_o`;
  4. wait until both power acks are 0;
  5. finish in state 0.
- R4: At most one control output changes per clock cycle. The SRAM line group counts as one output.
- R5: `sram_ack_i` bits whose `ACK_MASK` bit is 0 are ignored by both SRAM waits.
- R6: With an empty `ACK_MASK`, both SRAM waits are skipped. The step after the SRAM lines change follows in the next cycle.
- R7: With `USE_BUS_PROT`=0, `bus_prot_req_o` stays 0 and both protection steps are skipped.
- R8: A wait that stays unsatisfied for `TIMEOUT_CYC` cycles moves the block to state 2:
  - `err_o`=1 and `busy_o`=0;
  - control outputs are frozen;
  - with the default parameters, the fault is first visible 19 cycles after a power-up request whose power acks never arrive.
- R9: Requests that arrive while `busy_o` is 1 are ignored.
- R10: A request for the state the domain is already in gives `done_o` one cycle later and changes no control output.
- R11: When both requests are high together, `off_req_i` wins.
- R12: From state 2, `on_req_i` restarts power-up and `off_req_i` restarts power-down; `err_o` clears as the sequence starts.
- R13: `done_o` is a single-cycle pulse, raised in the first cycle that `state_o` shows 0 or 1 after a sequence. `busy_o` is 1 for every cycle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_req_i | input | 1 | Request power-up |
| off_req_i | input | 1 | Request power-down |
| pwr_ack_i | input | 1 | Primary switch status |
| pwr_ack2_i | input | 1 | Secondary switch status |
| sram_ack_i | input | ACK_W | SRAM power-down acknowledges |
| bus_prot_ack_i | input | 1 | Bus protection acknowledge |
| rst_rel_o | output | 1 | Domain reset release (0 = in reset) |
| iso_o | output | 1 | Isolation enable |
| pwr_on_o | output | 1 | Primary power switch enable |
| pwr_on2_o | output | 1 | Secondary power switch enable |
| clk_dis_o | output | 1 | Domain clock disable |
| sram_pdn_o | output | SRAM_W | SRAM power-down lines |
| bus_prot_req_o | output | 1 | Bus protection request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed pulse |
| err_o | output | 1 | Timeout fault |
| state_o | output | 5 | Sequencer state code |

## Verification
Every control step is registered. A request seen at one edge therefore shows its first output change one cycle later, and each later step follows one cycle after the previous one or after the acknowledge that ends a wait.

A same-state request pulses `done_o` in the cycle after the request. With the power acks withheld, the fault appears exactly `TIMEOUT_CYC`+3 cycles after the request.

The bench samples on the falling edge. It logs every output change together with its cycle stamp, so it can check order, one-change-per-cycle and the gaps between steps without predicting ack arrival exactly. Pulses such as `done_o` are checked in the sample where they are due and again in the sample after.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [4:0] {
    ST_OFF   = 5'd0,
    ST_ON    = 5'd1,
    ST_FAULT = 5'd2,
    UP_PWR1, UP_PWR2, UP_WPWR, UP_CLK, UP_ISO, UP_RST, UP_SRAM, UP_WSRAM, UP_BP, UP_WBP,
    DN_BP, DN_WBP, DN_SRAM, DN_WSRAM, DN_ISO, DN_RST, DN_CLK, DN_PWR1, DN_PWR2, DN_WPWR
  } seq_state_e;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_PWR1_ON, ACT_PWR2_ON, ACT_CLK_EN, ACT_ISO_OFF, ACT_RST_REL, ACT_SRAM_UP, ACT_BP_REL,
    ACT_BP_SET, ACT_SRAM_DN, ACT_ISO_ON, ACT_RST_ON, ACT_CLK_DIS, ACT_PWR1_OFF, ACT_PWR2_OFF
  } seq_act_e;

  function automatic logic is_wait(seq_state_e s);
    return (s == UP_WPWR) || (s == UP_WSRAM) || (s == UP_WBP) ||
           (s == DN_WBP)  || (s == DN_WSRAM) || (s == DN_WPWR);
  endfunction

  function automatic logic is_idle(seq_state_e s);
    return (s == ST_OFF) || (s == ST_ON) || (s == ST_FAULT);
  endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  // reload whenever not waiting; waits are never back to back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= RELOAD;
    else if (!run_i)           cnt_q <= RELOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = run_i && (cnt_q == '0);

  // R8: a wait of fewer than LIMIT cycles never expires
  p_no_early_expire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !$past(run_i)) |-> (LIMIT < 2) || !expired_o);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned           ACK_W        = 4,
  parameter logic [ACK_W-1:0]      ACK_MASK     = 4'b0011,
  parameter bit                    USE_BUS_PROT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             on_req_i,
  input  logic             off_req_i,
  input  logic             pwr_ack_i,
  input  logic             pwr_ack2_i,
  input  logic [ACK_W-1:0] sram_ack_i,
  input  logic             bus_prot_ack_i,
  input  logic             tmr_expired_i,
  output seq_state_e       state_o,
  output seq_act_e         act_o,
  output logic             wait_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam bit HAS_SRAM_ACK = (ACK_MASK != '0);
  localparam seq_state_e UP_TAIL  = USE_BUS_PROT ? UP_BP : ST_ON;
  localparam seq_state_e DN_FIRST = USE_BUS_PROT ? DN_BP : DN_SRAM;
  localparam seq_state_e UP_AFTER_SRAM = HAS_SRAM_ACK ? UP_WSRAM : UP_TAIL;
  localparam seq_state_e DN_AFTER_SRAM = HAS_SRAM_ACK ? DN_WSRAM : DN_ISO;

  seq_state_e       state_q, state_d;
  logic             done_q, fin;
  logic [ACK_W-1:0] sram_masked;

  assign sram_masked = sram_ack_i & ACK_MASK;

  always_comb begin
    state_d = state_q;
    act_o   = ACT_NONE;
    fin     = 1'b0;
    case (state_q)
      ST_OFF: begin
        if (off_req_i)     fin = 1'b1;
        else if (on_req_i) state_d = UP_PWR1;
      end
      ST_ON: begin
        if (off_req_i)     state_d = DN_FIRST;
        else if (on_req_i) fin = 1'b1;
      end
      ST_FAULT: begin
        if (off_req_i)     state_d = DN_FIRST;
        else if (on_req_i) state_d = UP_PWR1;
      end
      UP_PWR1: begin act_o = ACT_PWR1_ON; state_d = UP_PWR2; end
      UP_PWR2: begin act_o = ACT_PWR2_ON; state_d = UP_WPWR; end
      UP_WPWR: begin
        if (pwr_ack_i && pwr_ack2_i) state_d = UP_CLK;
        else if (tmr_expired_i)      state_d = ST_FAULT;
      end
      UP_CLK:  begin act_o = ACT_CLK_EN;  state_d = UP_ISO;  end
      UP_ISO:  begin act_o = ACT_ISO_OFF; state_d = UP_RST;  end
      UP_RST:  begin act_o = ACT_RST_REL; state_d = UP_SRAM; end
      UP_SRAM: begin act_o = ACT_SRAM_UP; state_d = UP_AFTER_SRAM; end
      UP_WSRAM: begin
        if (sram_masked == '0)  state_d = UP_TAIL;
        else if (tmr_expired_i) state_d = ST_FAULT;
      end
      UP_BP:   begin act_o = ACT_BP_REL; state_d = UP_WBP; end
      UP_WBP: begin
        if (!bus_prot_ack_i)    state_d = ST_ON;
        else if (tmr_expired_i) state_d = ST_FAULT;
      end
      DN_BP:   begin act_o = ACT_BP_SET; state_d = DN_WBP; end
      DN_WBP: begin
        if (bus_prot_ack_i)     state_d = DN_SRAM;
        else if (tmr_expired_i) state_d = ST_FAULT;
      end
      DN_SRAM: begin act_o = ACT_SRAM_DN; state_d = DN_AFTER_SRAM; end
      DN_WSRAM: begin
        if (sram_masked == ACK_MASK) state_d = DN_ISO;
        else if (tmr_expired_i)      state_d = ST_FAULT;
      end
      DN_ISO:  begin act_o = ACT_ISO_ON;   state_d = DN_RST;  end
      DN_RST:  begin act_o = ACT_RST_ON;   state_d = DN_CLK;  end
      DN_CLK:  begin act_o = ACT_CLK_DIS;  state_d = DN_PWR1; end
      DN_PWR1: begin act_o = ACT_PWR1_OFF; state_d = DN_PWR2; end
      DN_PWR2: begin act_o = ACT_PWR2_OFF; state_d = DN_WPWR; end
      DN_WPWR: begin
        if (!pwr_ack_i && !pwr_ack2_i) state_d = ST_OFF;
        else if (tmr_expired_i)        state_d = ST_FAULT;
      end
      default: state_d = ST_FAULT;
    endcase
    if (!is_idle(state_q) && ((state_d == ST_ON) || (state_d == ST_OFF))) fin = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  assign state_o = state_q;
  assign wait_o  = is_wait(state_q);
  assign busy_o  = !is_idle(state_q);
  assign err_o   = (state_q == ST_FAULT);
  assign done_o  = done_q;

  // R13: completion only reported in a settled state
  p_done_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == ST_ON || state_q == ST_OFF));
  // R13: pulse lasts one cycle
  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8: fault entered only from a wait whose timer ran out
  p_fault_from_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT && $past(state_q) != ST_FAULT) |-> $past(tmr_expired_i));
  // R2: clock enable step only after both switch acks
  p_clk_after_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == UP_CLK) |-> $past(pwr_ack_i && pwr_ack2_i));
  // R3: off reached only with both switch acks low
  p_off_after_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && $past(state_q) == DN_WPWR) |-> $past(!pwr_ack_i && !pwr_ack2_i));
  // R9: a running sequence advances to its own next step regardless of requests
  p_busy_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> (state_q != UP_PWR1 && state_q != DN_FIRST));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SRAM_W       = 4,
  parameter bit          USE_BUS_PROT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_act_e          act_i,
  output logic              rst_rel_o,
  output logic              iso_o,
  output logic              pwr_on_o,
  output logic              pwr_on2_o,
  output logic              clk_dis_o,
  output logic [SRAM_W-1:0] sram_pdn_o,
  output logic              bus_prot_req_o
);
  logic rst_rel_q, iso_q, pwr_on_q, pwr_on2_q, clk_dis_q;
  logic [SRAM_W-1:0] sram_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_rel_q <= 1'b0;
      iso_q     <= 1'b1;
      pwr_on_q  <= 1'b0;
      pwr_on2_q <= 1'b0;
      clk_dis_q <= 1'b1;
      sram_q    <= '1;
    end else begin
      case (act_i)
        ACT_PWR1_ON:  pwr_on_q  <= 1'b1;
        ACT_PWR2_ON:  pwr_on2_q <= 1'b1;
        ACT_CLK_EN:   clk_dis_q <= 1'b0;
        ACT_ISO_OFF:  iso_q     <= 1'b0;
        ACT_RST_REL:  rst_rel_q <= 1'b1;
        ACT_SRAM_UP:  sram_q    <= '0;
        ACT_SRAM_DN:  sram_q    <= '1;
        ACT_ISO_ON:   iso_q     <= 1'b1;
        ACT_RST_ON:   rst_rel_q <= 1'b0;
        ACT_CLK_DIS:  clk_dis_q <= 1'b1;
        ACT_PWR1_OFF: pwr_on_q  <= 1'b0;
        ACT_PWR2_OFF: pwr_on2_q <= 1'b0;
        default: ;
      endcase
    end
  end

  generate
    if (USE_BUS_PROT) begin : g_bp
      logic bp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   bp_q <= 1'b1;
        else if (act_i == ACT_BP_SET)  bp_q <= 1'b1;
        else if (act_i == ACT_BP_REL)  bp_q <= 1'b0;
      end
      assign bus_prot_req_o = bp_q;

      // R2: protection released only with SRAM powered
      p_bp_rel_late_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(bp_q) |-> (sram_q == '0));
      // R3: SRAM lines go down only under protection
      p_bp_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sram_q == '1 && $past(sram_q) != '1) |-> bp_q);
    end else begin : g_no_bp
      assign bus_prot_req_o = 1'b0;
    end
  endgenerate

  assign rst_rel_o  = rst_rel_q;
  assign iso_o      = iso_q;
  assign pwr_on_o   = pwr_on_q;
  assign pwr_on2_o  = pwr_on2_q;
  assign clk_dis_o  = clk_dis_q;
  assign sram_pdn_o = sram_q;

  // R4: one control output (SRAM group as one) per cycle
  p_single_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rst_rel_q ^ $past(rst_rel_q), iso_q ^ $past(iso_q),
                pwr_on_q ^ $past(pwr_on_q), pwr_on2_q ^ $past(pwr_on2_q),
                clk_dis_q ^ $past(clk_dis_q), bus_prot_req_o ^ $past(bus_prot_req_o),
                sram_q != $past(sram_q)}) <= 1);
  // R2: secondary switch follows primary
  p_pwr2_after_pwr1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_on2_q) |-> pwr_on_q);
  // R2: isolation dropped only with the clock running
  p_iso_after_clk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iso_q) |-> !clk_dis_q);
  // R3: primary switch opened only once isolated and clock stopped
  p_pwr_off_safe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_on_q) |-> (iso_q && clk_dis_q && !rst_rel_q));

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned      SRAM_W       = 4,
  parameter int unsigned      ACK_W        = 4,
  parameter logic [ACK_W-1:0] ACK_MASK     = 4'b0011,
  parameter bit               USE_BUS_PROT = 1'b1,
  parameter int unsigned      TIMEOUT_CYC  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              on_req_i,
  input  logic              off_req_i,
  input  logic              pwr_ack_i,
  input  logic              pwr_ack2_i,
  input  logic [ACK_W-1:0]  sram_ack_i,
  input  logic              bus_prot_ack_i,
  output logic              rst_rel_o,
  output logic              iso_o,
  output logic              pwr_on_o,
  output logic              pwr_on2_o,
  output logic              clk_dis_o,
  output logic [SRAM_W-1:0] sram_pdn_o,
  output logic              bus_prot_req_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [4:0]        state_o
);
  seq_state_e state;
  seq_act_e   act;
  logic       waiting, expired;

  pwr_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(waiting), .expired_o(expired)
  );

  pwr_seq_fsm #(.ACK_W(ACK_W), .ACK_MASK(ACK_MASK), .USE_BUS_PROT(USE_BUS_PROT)) u_fsm (
    .clk_i, .rst_ni, .on_req_i, .off_req_i, .pwr_ack_i, .pwr_ack2_i, .sram_ack_i,
    .bus_prot_ack_i, .tmr_expired_i(expired), .state_o(state), .act_o(act),
    .wait_o(waiting), .busy_o, .done_o, .err_o
  );

  pwr_seq_ctrl #(.SRAM_W(SRAM_W), .USE_BUS_PROT(USE_BUS_PROT)) u_ctrl (
    .clk_i, .rst_ni, .act_i(act), .rst_rel_o, .iso_o, .pwr_on_o, .pwr_on2_o,
    .clk_dis_o, .sram_pdn_o, .bus_prot_req_o
  );

  assign state_o = state;

  // R8: busy and fault never together
  p_busy_err_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && err_o));
  // R8: outputs frozen while faulted
  p_fault_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && $past(err_o)) |-> ($stable(pwr_on_o) && $stable(iso_o) && $stable(sram_pdn_o)));

endmodule

// File: tb/pwr_domain_seq_tb.sv
module pwr_domain_seq_tb_top;
  localparam int T = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk_i) cyc = cyc + 1;

  // ---- instance A: default (mask 0011, bus protection) ----
  logic on_a = 0, off_a = 0, pa_a, pb_a, bpa_a;
  logic [3:0] sa_a;
  logic rr_a, iso_a, p1_a, p2_a, cd_a, bp_a, busy_a, done_a, err_a;
  logic [3:0] sp_a;
  logic [4:0] st_a;

  pwr_domain_seq dut_i (
    .clk_i, .rst_ni, .on_req_i(on_a), .off_req_i(off_a), .pwr_ack_i(pa_a), .pwr_ack2_i(pb_a),
    .sram_ack_i(sa_a), .bus_prot_ack_i(bpa_a), .rst_rel_o(rr_a), .iso_o(iso_a),
    .pwr_on_o(p1_a), .pwr_on2_o(p2_a), .clk_dis_o(cd_a), .sram_pdn_o(sp_a),
    .bus_prot_req_o(bp_a), .busy_o(busy_a), .done_o(done_a), .err_o(err_a), .state_o(st_a)
  );

  // ---- instance B: empty mask, no bus protection ----
  logic on_b = 0, off_b = 0, pa_b, pb_b;
  logic rr_b, iso_b, p1_b, p2_b, cd_b, bp_b, busy_b, done_b, err_b;
  logic [3:0] sp_b;
  logic [4:0] st_b;

  pwr_domain_seq #(.ACK_MASK(4'b0000), .USE_BUS_PROT(1'b0)) dut_b_i (
    .clk_i, .rst_ni, .on_req_i(on_b), .off_req_i(off_b), .pwr_ack_i(pa_b), .pwr_ack2_i(pb_b),
    .sram_ack_i(4'hF), .bus_prot_ack_i(1'b1), .rst_rel_o(rr_b), .iso_o(iso_b),
    .pwr_on_o(p1_b), .pwr_on2_o(p2_b), .clk_dis_o(cd_b), .sram_pdn_o(sp_b),
    .bus_prot_req_o(bp_b), .busy_o(busy_b), .done_o(done_b), .err_o(err_b), .state_o(st_b)
  );

  // ---- domain responders (update on falling edge) ----
  logic hold_pwr = 0, hold_sram = 0, hold_bp = 0;
  logic [2:0] psh_a = 0, qsh_a = 0, psh_b = 0, qsh_b = 0;
  logic [1:0] sr0 = 2'b11, sr1 = 2'b11;
  logic bp0 = 1, bp1 = 1;
  always @(negedge clk_i) begin
    if (!hold_pwr) begin
      psh_a = {psh_a[1:0], p1_a};
      qsh_a = {qsh_a[1:0], p2_a};
    end
    if (!hold_sram) begin sr1 = sr0; sr0 = sp_a[1:0]; end
    if (!hold_bp) begin bp1 = bp0; bp0 = bp_a; end
    psh_b = {psh_b[1:0], p1_b};
    qsh_b = {qsh_b[1:0], p2_b};
  end
  assign pa_a = psh_a[2];
  assign pb_a = qsh_a[2];
  assign sa_a = {~sr1, sr1};   // unmasked bits always opposite (R5)
  assign bpa_a = bp1;
  assign pa_b = psh_b[2];
  assign pb_b = qsh_b[2];

  // ---- change monitors: code = index*2 + new value ----
  // index: 0 rst_rel,1 iso,2 pwr_on,3 pwr_on2,4 clk_dis,5 sram group,6 bus_prot
  int lg_a[32], lc_a[32], n_a = 0, multi_a = 0;
  int lg_b[32], lc_b[32], n_b = 0, multi_b = 0;
  logic [6:0] pv_a, pv_b;
  logic [3:0] ps_a, ps_b;

  always @(negedge clk_i) begin
    logic [6:0] cur;
    int k;
    cur = {bp_a, |sp_a, cd_a, p2_a, p1_a, iso_a, rr_a};
    k = 0;
    if (rst_ni) begin
      for (int i = 0; i < 7; i++) begin
        if ((i == 5) ? (sp_a != ps_a) : (cur[i] != pv_a[i])) begin
          if (n_a < 32) begin lg_a[n_a] = i*2 + int'(cur[i]); lc_a[n_a] = cyc; n_a++; end
          k++;
        end
      end
      if (k > 1) multi_a++;
    end
    pv_a = cur; ps_a = sp_a;
  end

  always @(negedge clk_i) begin
    logic [6:0] cur;
    int k;
    cur = {bp_b, |sp_b, cd_b, p2_b, p1_b, iso_b, rr_b};
    k = 0;
    if (rst_ni) begin
      for (int i = 0; i < 7; i++) begin
        if ((i == 5) ? (sp_b != ps_b) : (cur[i] != pv_b[i])) begin
          if (n_b < 32) begin lg_b[n_b] = i*2 + int'(cur[i]); lc_b[n_b] = cyc; n_b++; end
          k++;
        end
      end
      if (k > 1) multi_b++;
    end
    pv_b = cur; ps_b = sp_b;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_logs();
    n_a = 0; multi_a = 0; n_b = 0; multi_b = 0;
  endtask

  task automatic chk_log(input bit use_b, input int e[7], input int len, input string req);
    int n;
    n = use_b ? n_b : n_a;
    chk(n == len, {req, " change count"}, n, len);
    for (int i = 0; i < len; i++) begin
      int got;
      got = use_b ? lg_b[i] : lg_a[i];
      if (i < n) chk(got == e[i], {req, " step order"}, got, e[i]);
    end
    chk((use_b ? multi_b : multi_a) == 0, "R4 one change per cycle", use_b ? multi_b : multi_a, 0);
  endtask

  // pulse a request (A) for one cycle, return sample count until done/err
  task automatic run_a(input bit on, input bit off, input bit poke_busy, output int n,
                       output bit busy_seen);
    n = 0; busy_seen = 0;
    @(negedge clk_i);
    on_a = on; off_a = off;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      on_a = 0; off_a = 0;
      n++;
      if (busy_a) busy_seen = 1;
      if (poke_busy && n == 3) begin on_a = 1; off_a = 1; end   // R9 stimulus
      if (done_a || err_a) break;
    end
  endtask

  task automatic run_b(input bit on, output int n, output int done_cyc);
    n = 0; done_cyc = 0;
    @(negedge clk_i);
    on_b = on; off_b = !on;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      on_b = 0; off_b = 0;
      n++;
      if (done_b || err_b) begin done_cyc = cyc; break; end
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(rr_a == 0 && iso_a == 1 && p1_a == 0 && p2_a == 0 && cd_a == 1, "R1 controls", {rr_a,iso_a,p1_a,p2_a,cd_a}, 5'b01001);
    chk(sp_a == 4'hF, "R1 sram", sp_a, 15);
    chk(bp_a == 1 && bp_b == 0, "R1 R7 bus prot", {bp_a, bp_b}, 2);
    chk(!busy_a && !done_a && !err_a && st_a == 0, "R1 status", {busy_a,done_a,err_a,st_a}, 0);
  endtask

  task automatic t_same_state_off();
    int n; bit b;
    clr_logs();
    run_a(1, 1, 0, n, b);   // both requests in off: R11 off wins, R10 completes at once
    chk(n == 1 && done_a, "R10 R11 done next cycle", n, 1);
    chk(st_a == 0, "R11 stays off", st_a, 0);
    @(negedge clk_i);
    chk(!done_a, "R13 done one cycle", done_a, 0);
    chk(n_a == 0, "R10 no output change", n_a, 0);
  endtask

  task automatic t_power_up();
    int n; bit b;
    int e[7] = '{5, 7, 8, 2, 1, 10, 12};
    clr_logs();
    run_a(1, 0, 1, n, b);
    chk(done_a && st_a == 1 && !err_a, "R2 R5 R9 reached on", st_a, 1);
    chk(b, "R13 busy during sequence", b, 1);
    @(negedge clk_i);
    chk(!done_a, "R13 done one cycle", done_a, 0);
    chk_log(0, e, 7, "R2");
    if (n_a == 7) chk(lc_a[6] - lc_a[5] >= 3, "R2 waits for SRAM acks", lc_a[6] - lc_a[5], 3);
    if (n_a == 7) chk(lc_a[2] - lc_a[1] >= 4, "R2 waits for power acks", lc_a[2] - lc_a[1], 4);
  endtask

  task automatic t_same_state_on();
    int n; bit b;
    clr_logs();
    run_a(1, 0, 0, n, b);
    chk(n == 1 && done_a && st_a == 1, "R10 on request while on", n, 1);
    @(negedge clk_i);
    chk(n_a == 0, "R10 no output change", n_a, 0);
  endtask

  task automatic t_power_down(input bit both);
    int n; bit b;
    int e[7] = '{13, 11, 3, 0, 9, 4, 6};
    clr_logs();
    run_a(both, 1, 0, n, b);
    chk(done_a && st_a == 0 && !err_a, both ? "R11 both requests go off" : "R3 reached off", st_a, 0);
    @(negedge clk_i);
    chk_log(0, e, 7, "R3");
    if (n_a == 7) chk(lc_a[1] - lc_a[0] >= 3, "R3 waits for protection ack", lc_a[1] - lc_a[0], 3);
  endtask

  task automatic t_variant_b();
    int n, dc;
    int eu[7] = '{5, 7, 8, 2, 1, 10, 0};
    int ed[7] = '{11, 3, 0, 9, 4, 6, 0};
    clr_logs();
    run_b(1, n, dc);
    chk(done_b && st_b == 1 && !err_b, "R6 empty mask reaches on", st_b, 1);
    @(negedge clk_i);
    chk_log(1, eu, 6, "R6 R7 up");
    if (n_b == 6) chk(lc_b[5] == dc, "R6 SRAM wait skipped", lc_b[5], dc);
    chk(bp_b == 0, "R7 no protection request", bp_b, 0);
    clr_logs();
    run_b(0, n, dc);
    chk(done_b && st_b == 0 && !err_b, "R6 R7 reaches off", st_b, 0);
    @(negedge clk_i);
    chk_log(1, ed, 6, "R7 down");
    if (n_b == 6) chk(lc_b[1] - lc_b[0] == 1, "R6 down SRAM wait skipped", lc_b[1] - lc_b[0], 1);
  endtask

  task automatic t_timeout_pwr();
    int n; bit b;
    hold_pwr = 1;
    run_a(1, 0, 0, n, b);
    chk(err_a && n == T + 3, "R8 timeout latency", n, T + 3);
    chk(st_a == 2 && !busy_a, "R8 fault state", st_a, 2);
    chk(cd_a == 1 && p1_a == 1 && p2_a == 1, "R8 R2 stopped before clock", {cd_a, p1_a, p2_a}, 7);
    repeat (3) @(negedge clk_i);
    chk(err_a && p1_a && cd_a, "R8 outputs frozen", {err_a, p1_a, cd_a}, 7);
    hold_pwr = 0;
    repeat (5) @(negedge clk_i);
    run_a(0, 1, 0, n, b);
    chk(done_a && st_a == 0 && !err_a, "R12 recovery to off", st_a, 0);
    chk(rr_a == 0 && iso_a && !p1_a && !p2_a && cd_a && sp_a == 4'hF && bp_a,
        "R12 off outputs", {rr_a, iso_a, p1_a, p2_a, cd_a}, 5'b01001);
  endtask

  task automatic t_timeout_sram();
    int n; bit b;
    hold_sram = 1;
    run_a(1, 0, 0, n, b);
    chk(err_a && st_a == 2, "R8 SRAM wait timeout", st_a, 2);
    chk(sp_a == 0 && bp_a == 1 && rr_a == 1, "R2 protection held until SRAM ack", bp_a, 1);
    hold_sram = 0;
    repeat (4) @(negedge clk_i);
    run_a(1, 0, 0, n, b);
    chk(done_a && st_a == 1 && !err_a && bp_a == 0, "R12 recovery to on", st_a, 1);
  endtask

  task automatic t_timeout_bp();
    int n; bit b;
    hold_bp = 1;
    run_a(0, 1, 0, n, b);
    chk(err_a && st_a == 2, "R8 protection wait timeout", st_a, 2);
    chk(bp_a == 1 && sp_a == 0 && iso_a == 0, "R3 SRAM untouched before protection ack", sp_a, 0);
    hold_bp = 0;
    repeat (4) @(negedge clk_i);
    run_a(0, 1, 0, n, b);
    chk(done_a && st_a == 0 && !err_a, "R12 fault to off", st_a, 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        t_reset();
        t_same_state_off();
        t_power_up();
        t_same_state_on();
        t_power_down(0);
        t_variant_b();
        t_timeout_pwr();
        t_timeout_sram();
        t_power_down(1);
        begin int n; bit b; run_a(1, 0, 0, n, b); end
        t_timeout_bp();
      end
      begin
        repeat (100000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule